// File: doc/BRIEF.md
# Special Instruction Availability Gate

This block sits in the decode stage of a processor that is paired with a fabric whose accelerators can be swapped at runtime. It keeps a small table with one entry for each special-instruction identifier. Each entry holds a small performance level that records how much accelerator hardware is currently loaded for that instruction. A level of zero means nothing usable is loaded.

When a special instruction is decoded, the block reads its entry in the same cycle. A zero level raises an unimplemented-instruction trap, and software then emulates the instruction. A nonzero level sends a start pulse to the accelerator side, together with the identifier and the level. The block then holds the pipeline stall until the accelerator reports completion. The operating system updates the table through a write port. It writes zero when reconfiguration of a slot begins and the final level when loading has finished, so a half-loaded slot is never dispatched to. Writes may arrive at any time, including while an accelerator is running.

Top module: `si_avail_gate`

## Requirements
- R1: After reset every table entry holds level 0, so every decode traps; `stall`, `trap` and `acc_start` are low while no decode is presented.
- R2: In a cycle with `dec_valid` high, the block idle, and the addressed entry at level 0, `trap` is high in that same cycle, while `acc_start` and `stall` stay low.
- R3: In a cycle with `dec_valid` high, the block idle, and the addressed entry at a nonzero level, `acc_start` is high in that same cycle. In that cycle `acc_sid` equals `dec_sid`, `acc_level` equals the entry's level, and `trap` is low.
- R4: `stall` is high from the dispatch cycle through the cycle in which `acc_done` is seen high. It is low in the following cycle unless a new dispatch occurs.
- R5: While an accelerator is running (after the dispatch cycle and up to and including the done cycle), `dec_valid` causes neither `trap` nor `acc_start`.
- R6: A write with `cfg_we` high sets entry `cfg_sid` to `cfg_level`. Lookups in later cycles see the new value. A lookup of the same entry in the write cycle sees the old value.
- R7: Writing level 0 to an entry makes later decodes of it trap. Writing a nonzero level makes later decodes dispatch with that level. All other entries are left unchanged.
- R8: Table writes made while an accelerator is running do not end or extend the stall. The stall still ends only on `acc_done`.
- R9: `acc_done` while no accelerator is running has no effect: `stall` stays low, and the next dispatch still stalls until its own done.
- R10: `trap` and `acc_start` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | A special instruction is in decode |
| dec_sid | input | 4 | Identifier of the decoded special instruction |
| cfg_we | input | 1 | Table write strobe from the OS side |
| cfg_sid | input | 4 | Entry being written |
| cfg_level | input | 2 | New level (0 = unavailable) |
| acc_done | input | 1 | Accelerator completion pulse |
| trap | output | 1 | Unimplemented-instruction trap |
| acc_start | output | 1 | Dispatch pulse to the accelerator |
| acc_sid | output | 4 | Identifier sent with the dispatch |
| acc_level | output | 2 | Level sent with the dispatch |
| stall | output | 1 | Pipeline stall |

## Verification
The assertions assume that `acc_done` belongs to the dispatch in flight. They also assume that the decode stage keeps presenting its instruction for as long as `stall` is high, so a decode seen while busy is a held copy and not a new instruction. The bench raises `acc_done` only after a dispatch, or deliberately while idle to check that it is ignored. It holds `dec_valid` high through every busy window. This means the idle-done case and the busy-decode case are both exercised without breaking the assumptions that the checker relies on.

// File: rtl/si_avail_pkg.sv
package si_avail_pkg;

  localparam int DEF_SID_W = 4;
  localparam int DEF_LVL_W = 2;

  // Decision made for one decode slot
  typedef enum logic [1:0] {
    ISSUE_NONE     = 2'd0,
    ISSUE_TRAP     = 2'd1,
    ISSUE_DISPATCH = 2'd2
  } issue_e;

  // A level is usable when any accelerator is loaded
  function automatic logic level_usable(input int unsigned lvl);
    return lvl != 0;
  endfunction

  // Decision rule: idle + valid picks trap or dispatch by level
  function automatic issue_e pick_issue(input logic valid, input logic busy,
                                        input int unsigned lvl);
    if (!valid || busy) return ISSUE_NONE;
    if (level_usable(lvl)) return ISSUE_DISPATCH;
    return ISSUE_TRAP;
  endfunction

endpackage

// File: rtl/si_level_table.sv
module si_level_table #(
  parameter int SID_W = 4,
  parameter int LVL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SID_W-1:0] wr_sid,
  input  logic [LVL_W-1:0] wr_lvl,
  input  logic [SID_W-1:0] rd_sid,
  output logic [LVL_W-1:0] rd_lvl
);
  localparam int ENTRIES = 1 << SID_W;

  logic [LVL_W-1:0] lvl_q [ENTRIES];

  // One register per entry; read is combinational, so a same-cycle
  // write is only seen after the edge.
  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_sid == SID_W'(e));
    always_ff @(posedge clk) begin
      if (!rst_n)   lvl_q[e] <= '0;
      else if (hit) lvl_q[e] <= wr_lvl;
    end
  end

  assign rd_lvl = lvl_q[rd_sid];

endmodule

// File: rtl/si_issue_ctrl.sv
module si_issue_ctrl #(
  parameter int LVL_W = 2
) (
  input  logic             dec_valid,
  input  logic             busy,
  input  logic [LVL_W-1:0] lvl,
  output logic             do_trap,
  output logic             do_dispatch
);
  import si_avail_pkg::*;

  issue_e decision;

  always_comb begin
    decision    = pick_issue(dec_valid, busy, int'(lvl));
    do_trap     = (decision == ISSUE_TRAP);
    do_dispatch = (decision == ISSUE_DISPATCH);
  end

endmodule

// File: rtl/si_busy_tracker.sv
module si_busy_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic done,
  output logic busy
);
  // Set on launch, cleared on the edge after done is seen while busy.
  always_ff @(posedge clk) begin
    if (!rst_n)            busy <= 1'b0;
    else if (launch)       busy <= 1'b1;
    else if (busy && done) busy <= 1'b0;
  end

endmodule

// File: rtl/si_avail_gate.sv
module si_avail_gate #(
  parameter int SID_W = si_avail_pkg::DEF_SID_W,
  parameter int LVL_W = si_avail_pkg::DEF_LVL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_valid,
  input  logic [SID_W-1:0] dec_sid,
  input  logic             cfg_we,
  input  logic [SID_W-1:0] cfg_sid,
  input  logic [LVL_W-1:0] cfg_level,
  input  logic             acc_done,
  output logic             trap,
  output logic             acc_start,
  output logic [SID_W-1:0] acc_sid,
  output logic [LVL_W-1:0] acc_level,
  output logic             stall
);

  logic [LVL_W-1:0] look_lvl;
  logic             busy_q;
  logic             fire_trap;
  logic             fire_dispatch;

  si_level_table #(.SID_W(SID_W), .LVL_W(LVL_W)) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_we),
    .wr_sid (cfg_sid),
    .wr_lvl (cfg_level),
    .rd_sid (dec_sid),
    .rd_lvl (look_lvl)
  );

  si_issue_ctrl #(.LVL_W(LVL_W)) u_issue (
    .dec_valid   (dec_valid),
    .busy        (busy_q),
    .lvl         (look_lvl),
    .do_trap     (fire_trap),
    .do_dispatch (fire_dispatch)
  );

  si_busy_tracker u_busy (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (fire_dispatch),
    .done   (acc_done),
    .busy   (busy_q)
  );

  assign trap      = fire_trap;
  assign acc_start = fire_dispatch;
  assign acc_sid   = fire_dispatch ? dec_sid  : '0;
  assign acc_level = fire_dispatch ? look_lvl : '0;
  assign stall     = fire_dispatch || busy_q;

endmodule

// File: rtl/si_avail_chk.sv
module si_avail_chk #(
  parameter int SID_W = 4,
  parameter int LVL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dec_valid,
  input logic             acc_done,
  input logic             trap,
  input logic             acc_start,
  input logic [LVL_W-1:0] acc_level,
  input logic             stall,
  input logic             busy
);

  AST_TRAP_NEEDS_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> dec_valid && !stall); // R2

  AST_START_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start |-> acc_level != '0); // R3

  AST_START_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start |-> stall); // R4

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start || (busy && !acc_done)) |=> busy && stall); // R4

  AST_BUSY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && acc_done) |=> !busy); // R4

  AST_NO_ISSUE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !acc_start && !trap); // R5

  AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !acc_start) |=> !busy); // R9

  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap && acc_start)); // R10

endmodule

bind si_avail_gate si_avail_chk #(.SID_W(SID_W), .LVL_W(LVL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dec_valid (dec_valid),
  .acc_done  (acc_done),
  .trap      (trap),
  .acc_start (acc_start),
  .acc_level (acc_level),
  .stall     (stall),
  .busy      (busy_q)
);

// File: tb/tb_si_avail_gate.sv
`timescale 1ns/1ps
module tb_si_avail_gate;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       dec_valid;
  logic [3:0] dec_sid;
  logic       cfg_we;
  logic [3:0] cfg_sid;
  logic [1:0] cfg_level;
  logic       acc_done;
  logic       trap;
  logic       acc_start;
  logic [3:0] acc_sid;
  logic [1:0] acc_level;
  logic       stall;

  int checks = 0;
  int errors = 0;
  int model [16];
  bit finished = 0;

  always #4 clk = ~clk; // 125 MHz

  si_avail_gate dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic eq(input string req, input string what, input int act, input int exp);
    chk(act == exp, req, what, act, exp);
  endtask

  task automatic write_entry(input int sid, input int lvl);
    @(posedge clk); #1;
    cfg_we = 1; cfg_sid = 4'(sid); cfg_level = 2'(lvl);
    @(posedge clk); #1;
    cfg_we = 0;
    model[sid] = lvl;
  endtask

  // Decode one instruction; a dispatch waits dly busy cycles then done.
  task automatic do_decode(input int sid, input int dly, input string req);
    int exp_lvl;
    exp_lvl = model[sid];
    @(posedge clk); #1;
    dec_valid = 1; dec_sid = 4'(sid);
    @(negedge clk);
    if (exp_lvl == 0) begin
      eq({req, "/R2"}, "trap", int'(trap), 1);
      eq({req, "/R2"}, "start", int'(acc_start), 0);
      eq({req, "/R2"}, "stall", int'(stall), 0);
      @(posedge clk); #1;
      dec_valid = 0;
    end else begin
      eq({req, "/R3"}, "start", int'(acc_start), 1);
      eq({req, "/R3"}, "sid", int'(acc_sid), sid);
      eq({req, "/R3"}, "level", int'(acc_level), exp_lvl);
      eq({req, "/R10"}, "trap", int'(trap), 0);
      eq({req, "/R4"}, "stall", int'(stall), 1);
      @(posedge clk); #1;
      for (int i = 0; i < dly; i++) begin
        @(negedge clk);
        eq("R4", "stall busy", int'(stall), 1);
        eq("R5", "trap busy", int'(trap), 0);
        eq("R5", "start busy", int'(acc_start), 0);
        @(posedge clk); #1;
      end
      acc_done = 1;
      @(negedge clk);
      eq("R4", "stall done cycle", int'(stall), 1);
      eq("R5", "start done cycle", int'(acc_start), 0);
      @(posedge clk); #1;
      acc_done = 0; dec_valid = 0;
      @(negedge clk);
      eq("R4", "stall after done", int'(stall), 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; dec_valid = 0; dec_sid = 0; cfg_we = 0; cfg_sid = 0;
    cfg_level = 0; acc_done = 0;
    for (int s = 0; s < 16; s++) model[s] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    eq("R1", "stall", int'(stall), 0);
    eq("R1", "trap", int'(trap), 0);
    eq("R1", "start", int'(acc_start), 0);

    // R1: every entry empty after reset
    for (int s = 0; s < 16; s++) do_decode(s, 0, "R1");

    // R7 sweep: each round loads a shifted level pattern into all entries
    for (int r = 0; r < 4; r++) begin
      for (int s = 0; s < 16; s++) write_entry(s, (s + r) % 4);
      for (int s = 0; s < 16; s++) do_decode(s, (s + r) % 3, "R7");
    end

    // R6: same-cycle write and lookup sees the old value
    write_entry(5, 0);
    @(posedge clk); #1;
    cfg_we = 1; cfg_sid = 4'd5; cfg_level = 2'd2;
    dec_valid = 1; dec_sid = 4'd5;
    @(negedge clk);
    eq("R6", "old-value trap", int'(trap), 1);
    eq("R6", "old-value start", int'(acc_start), 0);
    @(posedge clk); #1;
    cfg_we = 0; dec_valid = 0;
    model[5] = 2;
    do_decode(5, 1, "R6");

    // R8: writes during a running accelerator
    write_entry(6, 1);
    @(posedge clk); #1;
    dec_valid = 1; dec_sid = 4'd5;
    @(negedge clk);
    eq("R8", "start", int'(acc_start), 1);
    @(posedge clk); #1;
    cfg_we = 1; cfg_sid = 4'd5; cfg_level = 2'd0;
    @(negedge clk);
    eq("R8", "stall during write", int'(stall), 1);
    @(posedge clk); #1;
    cfg_sid = 4'd6; cfg_level = 2'd3;
    @(negedge clk);
    eq("R8", "stall during write 2", int'(stall), 1);
    @(posedge clk); #1;
    cfg_we = 0;
    model[5] = 0; model[6] = 3;
    @(negedge clk);
    eq("R8", "stall after writes", int'(stall), 1);
    @(posedge clk); #1;
    acc_done = 1;
    @(negedge clk);
    eq("R8", "stall done", int'(stall), 1);
    @(posedge clk); #1;
    acc_done = 0; dec_valid = 0;
    @(negedge clk);
    eq("R8", "stall released", int'(stall), 0);
    do_decode(5, 0, "R8");
    do_decode(6, 2, "R8");

    // R9: done while idle is ignored
    @(posedge clk); #1;
    acc_done = 1;
    @(negedge clk);
    eq("R9", "stall idle done", int'(stall), 0);
    @(posedge clk); #1;
    acc_done = 0;
    @(negedge clk);
    eq("R9", "stall after idle done", int'(stall), 0);
    do_decode(6, 3, "R9");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule